// File: doc/BRIEF.md
# Prescaled Up/Down Wrap Counter

This block keeps an 8-bit count that moves by one in either direction, but only when an internal divider says so. A free-running prescaler divides the fast system clock by a parameter `DIV`. Each time the prescaler completes a period, the count takes one step. The direction input picks the direction of that step. Overflow and underflow wrap modulo 256, so the count never saturates.

The direction can be changed at any time. The next step is taken from whatever value the count holds at that moment, with no jump and no restart. The reset is synchronous and active low. It clears both the count and the prescaler, so the first step after reset comes one full prescale period later. For a 100 MHz clock, the default `DIV` of 25,000,000 gives about four steps per second. A bench can set `DIV` to a small value, or to 1, so that the count steps on every edge.

Top module: `updn_tick_counter`

## Requirements
- R1: `count` is 8 bits wide and reads 0 on the cycle after any rising edge at which `rst_n` is low.
- R2: A low `rst_n` at a rising edge clears the count and restarts the prescale period, whatever the count value and whatever the prescaler phase.
- R3: At a step with `dir_down` = 0, the count becomes its previous value plus one.
- R4: At a step with `dir_down` = 1, the count becomes its previous value minus one.
- R5: Stepping up from 255 gives 0.
- R6: Stepping down from 0 gives 255.
- R7: When `dir_down` changes between steps, the next step starts from the current value. For example, 1, 2 followed by a change to down gives 1, 0, 255.
- R8: The count holds its value on every edge that is not a step edge. Out of reset, step edges come exactly once every `DIV` rising edges.
- R9: After `rst_n` returns high, the first step happens on the `DIV`-th rising edge that samples `rst_n` high.
- R10: With `DIV` = 1, the count steps on every rising edge at which `rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears count and prescaler |
| dir_down | input | 1 | Step direction: 0 counts up, 1 counts down |
| count | output | 8 | Registered count value |

## Verification
The count is a register fed from the prescaler's terminal-phase compare. A step is therefore visible one rising edge after the edge where the prescaler sits at `DIV`-1, and a reset is visible one edge after it is sampled low. The bench drives its inputs on the falling edge. It advances its own model of phase and count at each rising edge and compares 1 ns after that edge, so every check lands in the cycle where the result is due. Two copies of the block run side by side, one with `DIV` = 5 and one with `DIV` = 1. This exercises the first-step delay after reset, holding between ticks and single-cycle stepping under the same stimulus.

// File: rtl/updn_pkg.sv
package updn_pkg;

  // Direction encoding seen on the dir_down pin.
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  // Default sizing for a 100 MHz clock stepping at about 4 Hz.
  localparam int unsigned CNT_W_DEF = 8;
  localparam int unsigned DIV_DEF   = 25_000_000;

endpackage

// File: rtl/updn_prescaler.sv
module updn_prescaler #(
  parameter int unsigned DIV = updn_pkg::DIV_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  // Free-running phase; returns to zero after its terminal value.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + PW'(1);
    end
  end

  // Terminal phase: the edge that brings phase back to zero is a step edge.
  assign tick = (phase == LAST);

endmodule

// File: rtl/updn_stepper.sv
module updn_stepper #(
  parameter int unsigned W = updn_pkg::CNT_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         go_down,
  output logic [W-1:0] value
);

  // Modular step in both directions; wrap needs no special case.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (step_en) begin
      value <= go_down ? (value - W'(1)) : (value + W'(1));
    end
  end

endmodule

// File: rtl/updn_tick_counter.sv
module updn_tick_counter #(
  parameter int unsigned CNT_W = updn_pkg::CNT_W_DEF,
  parameter int unsigned DIV   = updn_pkg::DIV_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_down,
  output logic [CNT_W-1:0] count
);

  import updn_pkg::*;

  logic step_tick;
  dir_e dir_sel;

  assign dir_sel = dir_e'(dir_down);

  updn_prescaler #(.DIV(DIV)) u_prescaler (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (step_tick)
  );

  updn_stepper #(.W(CNT_W)) u_stepper (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_tick),
    .go_down (dir_sel == DIR_DOWN),
    .value   (count)
  );

endmodule

// File: rtl/updn_tick_counter_chk.sv
module updn_tick_counter_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DIV   = 25_000_000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_down,
  input logic [CNT_W-1:0] count,
  input logic             tick
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  bit was_in_reset = 1'b0;
  logic [31:0] gap;

  // R1/R2: one edge after a sampled reset the count reads zero.
  always @(posedge clk) begin
    if (was_in_reset) begin
      assert_reset_clears_R1: assert (count == '0)
        else $error("count not cleared after reset");
    end
    was_in_reset <= !rst_n;
  end

  // R8/R9: distance between ticks, counted from reset release.
  always @(posedge clk) begin
    if (!rst_n) begin
      gap <= 32'd0;
    end else if (tick) begin
      assert_tick_spacing_R8: assert (gap == DIV - 1)
        else $error("tick spacing %0d, want %0d", gap, DIV - 1);
      gap <= 32'd0;
    end else begin
      gap <= gap + 32'd1;
    end
  end

  assert_hold_between_ticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dir_down) |=> (count == $past(count) + CNT_W'(1)));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dir_down) |=> (count == $past(count) - CNT_W'(1)));

  assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dir_down && count == ALL_ONES) |=> (count == '0));

  assert_wrap_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dir_down && count == '0) |=> (count == ALL_ONES));

endmodule

bind updn_tick_counter updn_tick_counter_chk #(.CNT_W(CNT_W), .DIV(DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dir_down (dir_down),
  .count    (count),
  .tick     (step_tick)
);

// File: tb/updn_tick_counter_bench.sv
module updn_tick_counter_bench;

  localparam int unsigned BDIV = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_down = 1'b0;
  logic [7:0] count_a;
  logic [7:0] count_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state for the DIV=5 copy (a) and the DIV=1 copy (b).
  logic [7:0] ma = 8'd0;
  logic [7:0] mb = 8'd0;
  int         pa = 0;
  bit         first_pending = 1'b1;
  logic       last_dir = 1'b0;

  always #2.5 clk = ~clk;

  updn_tick_counter #(.CNT_W(8), .DIV(BDIV)) u_updn_tick_counter (
    .clk (clk), .rst_n (rst_n), .dir_down (dir_down), .count (count_a)
  );

  updn_tick_counter #(.CNT_W(8), .DIV(1)) u_updn_tick_counter_div1 (
    .clk (clk), .rst_n (rst_n), .dir_down (dir_down), .count (count_b)
  );

  function automatic logic [7:0] stepped(input logic [7:0] v, input logic d);
    return d ? (v - 8'd1) : (v + 8'd1);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: count=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cycle(input logic r, input logic d);
    logic [7:0] prev;
    int         prev_ph;
    bit         did_step;
    string      tag;
    @(negedge clk);
    rst_n = r;
    dir_down = d;
    @(posedge clk);
    prev = ma;
    prev_ph = pa;
    did_step = 1'b0;
    if (!r) begin
      ma = 8'd0;
      pa = 0;
      first_pending = 1'b1;
      mb = 8'd0;
    end else begin
      if (pa == BDIV - 1) begin
        pa = 0;
        ma = stepped(ma, d);
        did_step = 1'b1;
      end else begin
        pa++;
      end
      mb = stepped(mb, d);
    end
    #1;
    if (!r)                              tag = (prev != 0 || prev_ph != 0) ? "R2" : "R1";
    else if (!did_step)                  tag = "R8";
    else if (first_pending)              tag = "R9";
    else if (d != last_dir)              tag = "R7";
    else if (!d && prev == 8'hFF)        tag = "R5";
    else if (d && prev == 8'h00)         tag = "R6";
    else                                 tag = d ? "R4" : "R3";
    if (did_step) begin
      first_pending = 1'b0;
      last_dir = d;
    end
    check(tag, count_a, ma);
    check("R10", count_b, mb);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    for (int i = 0; i < 3; i++) run_cycle(1'b0, 1'b0);
    // R3, R9: 20 steps up
    for (int i = 0; i < 20 * BDIV; i++) run_cycle(1'b1, 1'b0);
    // R4, R7, R6: 25 steps down from 20 crosses zero
    for (int i = 0; i < 25 * BDIV; i++) run_cycle(1'b1, 1'b1);
    // R5, R7: 6 steps up from 251 crosses 255
    for (int i = 0; i < 6 * BDIV; i++) run_cycle(1'b1, 1'b0);
    // R2: reset in the middle of a prescale period
    for (int i = 0; i < 2; i++) run_cycle(1'b1, 1'b0);
    run_cycle(1'b0, 1'b1);
    // R9: first step after release while counting down
    for (int i = 0; i < 3 * BDIV; i++) run_cycle(1'b1, 1'b1);
    // Random mix of direction changes and occasional resets
    for (int i = 0; i < 800; i++) begin
      logic rr;
      logic dd;
      rr = (($urandom % 40) != 0);
      dd = (($urandom % 7) < 3) ? ~dir_down : dir_down;
      run_cycle(rr, dd);
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5 * 100_000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: count=%0d expected=%0d", count_a, ma);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule